// File: doc/BRIEF.md
# Inter-Processor Mailbox Controller

This block passes 32-bit command words between a host processor and a remote processor over three independent channels. The host sees two 64-bit register windows on a simple bus, chosen by a window-select input. The receive window has one read-only message slot per channel and four control registers: a routing mask, a pending-status register, an acknowledge register and an enable mask. The transmit window has one slot per channel. Writing the payload half of a transmit slot hands a message to the remote side through a single-cycle strobe.

The remote side deposits messages through a dedicated write port. The payload is always stored in the channel's receive slot. The channel's pending bit sets only when the channel is both enabled and routed. An active-high level interrupt stays asserted while any pending bit is set. The host reads the message and then writes a one to that channel's bit in the acknowledge register. Channel count, address width and data widths are parameters, and elaboration checks keep them consistent.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every register reads zero, `irq` is low, `tx_valid` is low and `bus_rdata` is zero.
- R2: The enable register (receive window, byte offset 0x4C00) and the routing register (0x4000) each store all 64 written bits and read back exactly what was written.
- R3: A remote deposit (`rmt_wr_en` high, channel `rmt_ch` below 3) stores `rmt_data` in that channel's receive slot at offset 0x100 + 8*channel. The payload reads back in bits 63:32 of the slot word, and bits 31:0 read zero. A deposit with `rmt_ch` equal to 3 changes nothing.
- R4: A deposit sets the channel's pending bit only if that channel's bit is one in both the enable register and the routing register as they stand before that cycle's edge. The status register (0x4400) shows pending bit i in bit i, and its bits 63:3 read zero.
- R5: Writing the acknowledge register (0x4800) clears every pending bit whose written bit is one. Bits written as zero leave the pending bits unchanged. The acknowledge register reads zero.
- R6: If a deposit that is allowed to set a channel's pending bit coincides with an acknowledge of that channel, the pending bit stays set. If the deposit is not allowed to set it, the acknowledge clears it.
- R7: `irq` is high exactly while at least one pending bit is set. It changes in the cycle after the edge that changes the pending bits.
- R8: A bus write to transmit-window slot i produces `tx_valid` high for the one following cycle, with `tx_ch` = i and `tx_data` = write data bits 63:32. That transmit slot then reads back the payload in bits 63:32. Writes to transmit-window offsets other than a slot produce no strobe.
- R9: Reads of unmapped offsets in either window return zero, and writes to them have no effect. Writes to the status register and to receive slots are ignored.
- R10: `bus_rdata` shows the read result in the cycle after `bus_rd_en` is sampled and holds it until the next read. A read returns register values from before a write sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Host register write request |
| bus_rd_en | input | 1 | Host register read request |
| bus_win_tx | input | 1 | Window select: 0 receive window, 1 transmit window |
| bus_addr | input | ADDR_W (15) | Byte offset of the 64-bit register |
| bus_wdata | input | REG_W (64) | Host write data |
| bus_rdata | output | REG_W (64) | Registered host read data |
| rmt_wr_en | input | 1 | Remote deposit strobe |
| rmt_ch | input | clog2(NUM_CH) (2) | Remote deposit channel index |
| rmt_data | input | PAY_W (32) | Remote deposit payload |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_ch | output | clog2(NUM_CH) (2) | Channel of the transmitted message |
| tx_data | output | PAY_W (32) | Transmitted payload |
| irq | output | 1 | Level interrupt, active high |

## Verification
Every state change happens at the edge where its request is sampled. Pending bits, `irq`, the transmit strobe and read data are all due one cycle after the stimulus. The bench drives each stimulus on a falling edge and samples the results on the next falling edge, half a cycle after the edge that registered them. It then looks at the cycle after that to confirm that the transmit strobe has dropped and that read data holds. The bench sweeps every channel against all four enable/route combinations, and it aims dedicated cycles at deposit-versus-acknowledge collisions, an out-of-range channel index, read-only targets and unmapped offsets.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

   localparam int unsigned SLOT_BASE   = 32'h0000_0100;
   localparam int unsigned SLOT_STRIDE = 8;
   localparam int unsigned ROUTE_OFS   = 32'h0000_4000;
   localparam int unsigned STAT_OFS    = 32'h0000_4400;
   localparam int unsigned ACK_OFS     = 32'h0000_4800;
   localparam int unsigned ENA_OFS     = 32'h0000_4C00;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SLOT,
      SEL_ROUTE,
      SEL_STAT,
      SEL_ACK,
      SEL_ENA
   } reg_sel_e;

endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned ADDR_W = 15
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [NUM_CH-1:0] slot_hit
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
      localparam int unsigned SLOT_ADDR = SLOT_BASE + SLOT_STRIDE * i;
      assign slot_hit[i] = (addr == ADDR_W'(SLOT_ADDR));
   end

   always_comb begin
      sel = SEL_NONE;
      if (|slot_hit)                        sel = SEL_SLOT;
      else if (addr == ADDR_W'(ROUTE_OFS))  sel = SEL_ROUTE;
      else if (addr == ADDR_W'(STAT_OFS))   sel = SEL_STAT;
      else if (addr == ADDR_W'(ACK_OFS))    sel = SEL_ACK;
      else if (addr == ADDR_W'(ENA_OFS))    sel = SEL_ENA;
   end

endmodule

// File: rtl/ipc_mbox_rx_chan.sv
module ipc_mbox_rx_chan #(
   parameter int unsigned PAY_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arrive,
   input  logic [PAY_W-1:0] arrive_data,
   input  logic             allow,
   input  logic             ack,
   output logic [PAY_W-1:0] payload_q,
   output logic             pend_q
);

   logic set_pend;
   assign set_pend = arrive & allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         payload_q <= '0;
         pend_q    <= 1'b0;
      end else begin
         if (arrive) payload_q <= arrive_data;
         // a permitted arrival takes priority over a same-cycle acknowledge
         if (set_pend)  pend_q <= 1'b1;
         else if (ack)  pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ipc_mbox_tx.sv
module ipc_mbox_tx #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned PAY_W  = 32,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH-1:0]            hit,
   input  logic [PAY_W-1:0]             wr_payload,
   output logic [NUM_CH-1:0][PAY_W-1:0] slot_q,
   output logic                         tx_valid,
   output logic [CH_W-1:0]              tx_ch,
   output logic [PAY_W-1:0]             tx_data
);

   logic [CH_W-1:0] hit_idx;

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (hit[i]) hit_idx = CH_W'(i);
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      slot_q[i] <= '0;
         else if (hit[i]) slot_q[i] <= wr_payload;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_ch    <= '0;
         tx_data  <= '0;
      end else begin
         tx_valid <= |hit;
         if (|hit) begin
            tx_ch   <= hit_idx;
            tx_data <= wr_payload;
         end
      end
   end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned PAY_W  = 32,
   parameter int unsigned REG_W  = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr_en,
   input  logic                       bus_rd_en,
   input  logic                       bus_win_tx,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [REG_W-1:0]           bus_wdata,
   output logic [REG_W-1:0]           bus_rdata,
   input  logic                       rmt_wr_en,
   input  logic [$clog2(NUM_CH)-1:0]  rmt_ch,
   input  logic [PAY_W-1:0]           rmt_data,
   output logic                       tx_valid,
   output logic [$clog2(NUM_CH)-1:0]  tx_ch,
   output logic [PAY_W-1:0]           tx_data,
   output logic                       irq
);

   localparam int unsigned CH_W     = $clog2(NUM_CH);
   localparam int unsigned SLOT_END = SLOT_BASE + SLOT_STRIDE * NUM_CH;

   // elaboration-time parameter checks
   if (NUM_CH < 2 || NUM_CH > REG_W) begin : g_bad_ch
      $error("ipc_mailbox: NUM_CH must lie between 2 and REG_W");
   end
   if (REG_W != 2 * PAY_W) begin : g_bad_w
      $error("ipc_mailbox: REG_W must be twice PAY_W");
   end
   if ((1 << ADDR_W) <= ENA_OFS) begin : g_bad_a
      $error("ipc_mailbox: ADDR_W too narrow for the register map");
   end
   if (SLOT_END > ROUTE_OFS) begin : g_bad_slots
      $error("ipc_mailbox: channel slots overlap control registers");
   end

   reg_sel_e                   sel;
   logic [NUM_CH-1:0]          slot_hit;
   logic                       wr_rx, wr_tx;
   logic [REG_W-1:0]           map_q, en_q;
   logic [NUM_CH-1:0]          pend_q;
   logic [NUM_CH-1:0]          ack_vec;
   logic [NUM_CH-1:0]          arrive_vec;
   logic [NUM_CH-1:0]          tx_hit;
   logic                       rmt_ok;
   logic [NUM_CH-1:0][PAY_W-1:0] rx_pay;
   logic [NUM_CH-1:0][PAY_W-1:0] tx_pay;
   logic [REG_W-1:0]           rd_mux;

   ipc_mbox_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) decode_i (
      .addr     (bus_addr),
      .sel      (sel),
      .slot_hit (slot_hit)
   );

   assign wr_rx  = bus_wr_en & ~bus_win_tx;
   assign wr_tx  = bus_wr_en &  bus_win_tx;
   assign rmt_ok = rmt_wr_en && (int'(rmt_ch) < NUM_CH);

   // routing and enable masks keep every written bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
         en_q  <= '0;
      end else if (wr_rx) begin
         if (sel == SEL_ROUTE) map_q <= bus_wdata;
         if (sel == SEL_ENA)   en_q  <= bus_wdata;
      end
   end

   assign ack_vec = (wr_rx && sel == SEL_ACK) ? bus_wdata[NUM_CH-1:0] : '0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      assign arrive_vec[i] = rmt_ok && (int'(rmt_ch) == i);

      ipc_mbox_rx_chan #(
         .PAY_W (PAY_W)
      ) chan_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .arrive      (arrive_vec[i]),
         .arrive_data (rmt_data),
         .allow       (en_q[i] & map_q[i]),
         .ack         (ack_vec[i]),
         .payload_q   (rx_pay[i]),
         .pend_q      (pend_q[i])
      );
   end

   assign tx_hit = (wr_tx && sel == SEL_SLOT) ? slot_hit : '0;

   ipc_mbox_tx #(
      .NUM_CH (NUM_CH),
      .PAY_W  (PAY_W)
   ) tx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (tx_hit),
      .wr_payload (bus_wdata[REG_W-1:PAY_W]),
      .slot_q     (tx_pay),
      .tx_valid   (tx_valid),
      .tx_ch      (tx_ch),
      .tx_data    (tx_data)
   );

   // read selection: transmit window exposes only its slots
   always_comb begin
      rd_mux = '0;
      if (sel == SEL_SLOT) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (slot_hit[i]) begin
               rd_mux = bus_win_tx ? {tx_pay[i], PAY_W'(0)}
                                   : {rx_pay[i], PAY_W'(0)};
            end
         end
      end else if (!bus_win_tx) begin
         case (sel)
            SEL_ROUTE: rd_mux = map_q;
            SEL_STAT:  rd_mux = REG_W'(pend_q);
            SEL_ENA:   rd_mux = en_q;
            default:   rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_mux;
   end

   assign irq = |pend_q;

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned REG_W  = 64
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_wr_en,
   input logic                      bus_rd_en,
   input logic                      bus_win_tx,
   input logic [REG_W-1:0]          bus_rdata,
   input logic                      rmt_wr_en,
   input logic [$clog2(NUM_CH)-1:0] rmt_ch,
   input logic                      tx_valid,
   input logic                      irq,
   input logic [REG_W-1:0]          en_q,
   input logic [REG_W-1:0]          map_q,
   input logic [NUM_CH-1:0]         pend_q
);

   AST_TX_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_wr_en && bus_win_tx)); // R8

   AST_RX_WRITE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !bus_win_tx) |=> !tx_valid); // R8

   AST_PEND_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(pend_q) > $past($countones(pend_q))) |-> $past(rmt_wr_en)); // R4

   AST_ARRIVAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (rmt_wr_en && (int'(rmt_ch) < NUM_CH) && en_q[rmt_ch] && map_q[rmt_ch]) |=> irq); // R6

   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !bus_wr_en) |=> irq); // R7

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> $stable(bus_rdata)); // R10

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
   .NUM_CH (NUM_CH),
   .REG_W  (REG_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr_en  (bus_wr_en),
   .bus_rd_en  (bus_rd_en),
   .bus_win_tx (bus_win_tx),
   .bus_rdata  (bus_rdata),
   .rmt_wr_en  (rmt_wr_en),
   .rmt_ch     (rmt_ch),
   .tx_valid   (tx_valid),
   .irq        (irq),
   .en_q       (en_q),
   .map_q      (map_q),
   .pend_q     (pend_q)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;

   localparam logic [14:0] A_ROUTE = 15'h4000;
   localparam logic [14:0] A_STAT  = 15'h4400;
   localparam logic [14:0] A_ACK   = 15'h4800;
   localparam logic [14:0] A_ENA   = 15'h4C00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0, bus_win_tx = 1'b0;
   logic [14:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        rmt_wr_en = 1'b0;
   logic [1:0]  rmt_ch = '0;
   logic [31:0] rmt_data = '0;
   logic        tx_valid;
   logic [1:0]  tx_ch;
   logic [31:0] tx_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ipc_mailbox dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_win_tx(bus_win_tx),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rmt_wr_en(rmt_wr_en), .rmt_ch(rmt_ch), .rmt_data(rmt_data),
      .tx_valid(tx_valid), .tx_ch(tx_ch), .tx_data(tx_data), .irq(irq)
   );

   function automatic logic [14:0] slot_addr(input int ch);
      return 15'(32'h100 + 8 * ch);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic win, input logic [14:0] a, input logic [63:0] d);
      bus_wr_en = 1'b1; bus_win_tx = win; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_win_tx = 1'b0;
   endtask

   task automatic bus_read(input logic win, input logic [14:0] a, output logic [63:0] d);
      bus_rd_en = 1'b1; bus_win_tx = win; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_rd_en = 1'b0; bus_win_tx = 1'b0;
   endtask

   task automatic rmt_send(input logic [1:0] ch, input logic [31:0] d);
      rmt_wr_en = 1'b1; rmt_ch = ch; rmt_data = d;
      @(negedge clk);
      rmt_wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] rd;
      logic [63:0] pat;
      logic [63:0] env, mpv, exp_st;
      logic [31:0] pay;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", "rdata at reset", bus_rdata, 64'h0);
      check("R1", "irq at reset", 64'(irq), 64'h0);
      check("R1", "tx_valid at reset", 64'(tx_valid), 64'h0);
      bus_read(1'b0, A_ROUTE, rd); check("R1", "route reset", rd, 64'h0);
      bus_read(1'b0, A_ENA, rd);   check("R1", "enable reset", rd, 64'h0);
      bus_read(1'b0, A_STAT, rd);  check("R1", "status reset", rd, 64'h0);
      for (int ch = 0; ch < 3; ch++) begin
         bus_read(1'b0, slot_addr(ch), rd); check("R1", "rx slot reset", rd, 64'h0);
         bus_read(1'b1, slot_addr(ch), rd); check("R1", "tx slot reset", rd, 64'h0);
      end

      // R2: full-width readback of route and enable
      for (int k = 0; k < 4; k++) begin
         pat = 64'hDEAD_BEEF_0123_4567 * 64'(k + 1);
         if (k == 3) pat = '1;
         bus_write(1'b0, A_ENA, pat);
         bus_write(1'b0, A_ROUTE, ~pat);
         bus_read(1'b0, A_ENA, rd);   check("R2", "enable readback", rd, pat);
         bus_read(1'b0, A_ROUTE, rd); check("R2", "route readback", rd, ~pat);
      end
      bus_write(1'b0, A_ENA, 64'h0);
      bus_write(1'b0, A_ROUTE, 64'h0);

      // R3 R4 R5 R7: every channel against every enable/route combination
      for (int ch = 0; ch < 3; ch++) begin
         for (int c = 0; c < 4; c++) begin
            env = 64'hA5A5_0000_0000_0000 | (64'(c & 1) << ch);
            mpv = 64'h0000_5A5A_0000_0000 | (64'((c >> 1) & 1) << ch);
            pay = 32'h1000_0000 + 32'(ch * 16 + c);
            exp_st = (c == 3) ? (64'h1 << ch) : 64'h0;
            bus_write(1'b0, A_ENA, env);
            bus_write(1'b0, A_ROUTE, mpv);
            rmt_send(2'(ch), pay);
            check("R7", "irq after deposit", 64'(irq), 64'(c == 3));
            bus_read(1'b0, A_STAT, rd);  check("R4", "status after deposit", rd, exp_st);
            bus_read(1'b0, slot_addr(ch), rd); check("R3", "rx slot payload", rd, {pay, 32'h0});
            bus_write(1'b0, A_ACK, ~(64'h1 << ch));
            bus_read(1'b0, A_STAT, rd);  check("R5", "zero ack bits keep pending", rd, exp_st);
            bus_write(1'b0, A_ACK, 64'h1 << ch);
            check("R7", "irq after ack", 64'(irq), 64'h0);
            bus_read(1'b0, A_STAT, rd);  check("R5", "ack clears pending", rd, 64'h0);
         end
      end
      bus_read(1'b0, A_ACK, rd); check("R5", "ack register reads zero", rd, 64'h0);

      // R6: deposit and acknowledge in the same cycle
      bus_write(1'b0, A_ENA, '1);
      bus_write(1'b0, A_ROUTE, '1);
      rmt_send(2'd1, 32'hAAAA_0001);
      rmt_wr_en = 1'b1; rmt_ch = 2'd1; rmt_data = 32'hAAAA_0002;
      bus_write(1'b0, A_ACK, 64'h2);
      rmt_wr_en = 1'b0;
      bus_read(1'b0, A_STAT, rd); check("R6", "arrival beats ack", rd, 64'h2);
      check("R6", "irq stays with arrival", 64'(irq), 64'h1);
      bus_write(1'b0, A_ENA, 64'h0);
      rmt_wr_en = 1'b1; rmt_ch = 2'd1; rmt_data = 32'hAAAA_0003;
      bus_write(1'b0, A_ACK, 64'h2);
      rmt_wr_en = 1'b0;
      bus_read(1'b0, A_STAT, rd); check("R6", "disabled arrival loses to ack", rd, 64'h0);
      bus_read(1'b0, slot_addr(1), rd); check("R3", "payload latched while disabled", rd, {32'hAAAA_0003, 32'h0});

      // R3: out-of-range channel index
      bus_write(1'b0, A_ENA, '1);
      rmt_send(2'd3, 32'h5555_5555);
      bus_read(1'b0, A_STAT, rd); check("R3", "channel 3 sets nothing", rd, 64'h0);
      for (int ch = 0; ch < 3; ch++) begin
         bus_read(1'b0, slot_addr(ch), rd);
         check("R3", "channel 3 leaves slots", rd[63:32] == 32'h5555_5555 ? 64'h1 : 64'h0, 64'h0);
      end

      // R9: read-only targets and unmapped offsets
      rmt_send(2'd0, 32'h0BAD_F00D);
      bus_write(1'b0, A_STAT, '1);
      bus_read(1'b0, A_STAT, rd); check("R9", "status write ignored", rd, 64'h1);
      bus_write(1'b0, slot_addr(0), 64'hFFFF_FFFF_FFFF_FFFF);
      bus_read(1'b0, slot_addr(0), rd); check("R9", "rx slot write ignored", rd, {32'h0BAD_F00D, 32'h0});
      bus_write(1'b0, A_ACK, 64'h1);
      for (int k = 0; k < 6; k++) begin
         logic [14:0] ua;
         case (k)
            0: ua = 15'h0000;
            1: ua = 15'h0008;
            2: ua = 15'h0104;
            3: ua = 15'h0118;
            4: ua = 15'h4008;
            default: ua = 15'h7FF8;
         endcase
         bus_write(1'b0, ua, '1);
         bus_read(1'b0, ua, rd); check("R9", "unmapped rx read", rd, 64'h0);
         bus_read(1'b1, ua, rd); check("R9", "unmapped tx read", rd, 64'h0);
      end
      bus_write(1'b1, A_ROUTE, 64'h0);
      check("R8", "no strobe on non-slot tx write", 64'(tx_valid), 64'h0);
      bus_read(1'b0, A_ROUTE, rd); check("R9", "route unaffected by stray writes", rd, '1);
      bus_read(1'b0, A_ENA, rd);   check("R9", "enable unaffected by stray writes", rd, '1);

      // R8: transmit strobe sweep
      for (int ch = 0; ch < 3; ch++) begin
         pay = 32'hC000_0000 ^ (32'(ch) * 32'h0101_0101);
         bus_wr_en = 1'b1; bus_win_tx = 1'b1; bus_addr = slot_addr(ch);
         bus_wdata = {pay, 32'h1234_5678};
         @(negedge clk);
         bus_wr_en = 1'b0; bus_win_tx = 1'b0;
         check("R8", "tx_valid pulse", 64'(tx_valid), 64'h1);
         check("R8", "tx_ch", 64'(tx_ch), 64'(ch));
         check("R8", "tx_data", 64'(tx_data), 64'(pay));
         @(negedge clk);
         check("R8", "tx_valid drops", 64'(tx_valid), 64'h0);
         bus_read(1'b1, slot_addr(ch), rd); check("R8", "tx slot readback", rd, {pay, 32'h0});
      end

      // R10: read data holds, and a read sees pre-write values
      bus_read(1'b0, A_ENA, rd);
      @(negedge clk);
      check("R10", "rdata holds without read", bus_rdata, '1);
      bus_wr_en = 1'b1; bus_rd_en = 1'b1; bus_addr = A_ENA; bus_wdata = 64'h77;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_rd_en = 1'b0;
      check("R10", "read sees old value", bus_rdata, '1);
      bus_read(1'b0, A_ENA, rd); check("R10", "write then landed", rd, 64'h77);

      finish_run();
   end

endmodule